// File: doc/BRIEF.md
# PS/2 Keyboard Scan Code Receiver

This block listens to a keyboard on the two open-collector lines of a PS/2 port. It handles the device-to-host direction only. Both lines are sampled in a fast system clock domain. Each line passes through a synchroniser and a glitch filter. The receiver then shifts in one data bit on every falling edge of the filtered keyboard clock. Each 11-bit frame is checked for a low start bit, a high stop bit and odd parity.

Good bytes go to a small decoder that understands scan code set 2. The extended prefix (E0) and the release prefix (F0) are remembered and not reported. The next ordinary byte then produces a single key event. That event carries the key byte together with an extended flag and a released flag, and both remembered prefixes are cleared. A damaged frame produces an error strobe, drops any remembered prefixes and reports no key. A frame that stalls part way through is dropped after a programmable idle time.

The block is meant to feed a keymap or event queue elsewhere in the chip. All of its outputs are registered single-cycle strobes with qualifying data.

Top module: `ps2_key_rx`

## Requirements
- R1: After a synchronous reset, `key_valid_o`, `frame_err_o`, `key_ext_o` and `key_rel_o` are low. No key event is reported until a complete frame arrives.
- R2: A frame is 11 bits, each sampled on a falling edge of the keyboard clock, in this order: start (0), data bits 0 to 7 (least significant first), parity, stop (1). A correct frame whose byte is not E0 or F0 gives exactly one one-cycle `key_valid_o` pulse, with `key_code_o` equal to the byte.
- R3: A correct F0 byte produces no event. It sets the released flag reported with the next non-prefix byte.
- R4: A correct E0 byte produces no event. It sets the extended flag reported with the next non-prefix byte. The sequences E0 F0 xx and F0 E0 xx both report extended and released.
- R5: After a key event, both remembered prefixes are cleared, so the following plain byte reports neither flag.
- R6: A frame with even parity over its eight data bits plus its parity bit gives a one-cycle `frame_err_o` pulse and no key event. It also clears any remembered prefix.
- R7: A frame whose start bit is 1 or whose stop bit is 0 is treated as in R6.
- R8: If no falling clock edge arrives for more than `TIMEOUT_CYC` system cycles while a frame is partly received, the partial frame is dropped without an error. The next falling edge is then taken as a new start bit.
- R9: A level on either line that lasts fewer than `FILT_LEN` consecutive synchronised samples is ignored.
- R10: `key_valid_o` and `frame_err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Level of the PS/2 clock line (asynchronous) |
| ps2_dat_i | input | 1 | Level of the PS/2 data line (asynchronous) |
| key_valid_o | output | 1 | One-cycle strobe: a key event is present |
| key_code_o | output | 8 | Key byte of the event |
| key_ext_o | output | 1 | Event was preceded by the extended prefix |
| key_rel_o | output | 1 | Event is a key release |
| frame_err_o | output | 1 | One-cycle strobe: a frame failed start, stop or parity checks |

## Verification
The bench drives prefix orders that a naive decoder mishandles, in particular F0 before E0 and E0 F0 before an extended key. A decoder that cleared a flag on the second prefix, or that reported the prefix byte itself, would give a wrong or extra event. It places a bad frame between a prefix and its key byte. A design that kept the prefix across the error would report a false release or a false extended key. It also stops a frame after a few bits and resumes later, and it pulses the clock line for less than the filter length. Without the idle drop, the next frame would be misaligned and flagged as an error. Without the filter, the glitch would count as a start bit.

// File: rtl/ps2_key_pkg.sv
package ps2_key_pkg;

  localparam int unsigned FRAME_BITS = 11;
  localparam logic [7:0]  PFX_EXT    = 8'hE0;
  localparam logic [7:0]  PFX_REL    = 8'hF0;

  // Bit 0 arrives first; the last bit received lands in the MSB.
  typedef struct packed {
    logic       stop;
    logic       par;
    logic [7:0] data;
    logic       start;
  } ps2_frame_t;

  function automatic logic frame_good(ps2_frame_t f);
    return (!f.start) && f.stop && (^{f.par, f.data});
  endfunction

endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o
);

  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   level_q;
  logic                   sample;

  assign sample  = sync_q[SYNC_STAGES-1];
  assign level_o = level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end
  end

  // The output level flips only after FILT_LEN samples that all disagree with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      level_q <= 1'b1;
    end else if (sample != level_q) begin
      if (run_q == CW'(FILT_LEN - 1)) begin
        level_q <= sample;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  // R9: the level changes only to a value the synchroniser has presented, and only after a full run
  a_r9_follows_sample: assert property (@(posedge clk) disable iff (rst)
    !$stable(level_q) |-> (level_q == $past(sample)));
  a_r9_full_run: assert property (@(posedge clk) disable iff (rst)
    !$stable(level_q) |-> ($past(run_q) == CW'(FILT_LEN - 1)));

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_key_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 25000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kclk_i,
  input  logic       kdat_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       err_o
);

  localparam int unsigned TW   = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned BCW  = $clog2(FRAME_BITS);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shift_q;
  logic [BCW-1:0]        bit_cnt_q;
  logic [TW-1:0]         quiet_q;
  logic                  kclk_prev_q;
  logic                  fall;
  ps2_frame_t            nxt;

  assign fall = kclk_prev_q & ~kclk_i;
  assign nxt  = ps2_frame_t'({kdat_i, shift_q[FRAME_BITS-1:1]});

  always_ff @(posedge clk) begin
    if (rst) begin
      kclk_prev_q <= 1'b1;
      shift_q     <= '0;
      bit_cnt_q   <= '0;
      quiet_q     <= '0;
      byte_vld_o  <= 1'b0;
      byte_o      <= '0;
      err_o       <= 1'b0;
    end else begin
      kclk_prev_q <= kclk_i;
      byte_vld_o  <= 1'b0;
      err_o       <= 1'b0;
      if (fall) begin
        shift_q <= nxt;
        quiet_q <= '0;
        if (bit_cnt_q == LAST_BIT) begin
          bit_cnt_q <= '0;
          if (frame_good(nxt)) begin
            byte_vld_o <= 1'b1;
            byte_o     <= nxt.data;
          end else begin
            err_o <= 1'b1;
          end
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end else if (bit_cnt_q != '0) begin
        if (quiet_q == TW'(TIMEOUT_CYC)) begin
          bit_cnt_q <= '0;
          quiet_q   <= '0;
        end else begin
          quiet_q <= quiet_q + 1'b1;
        end
      end else begin
        quiet_q <= '0;
      end
    end
  end

  // R8: a stalled partial frame is dropped
  a_r8_stall_drop: assert property (@(posedge clk) disable iff (rst)
    (bit_cnt_q != '0 && !fall && quiet_q == TW'(TIMEOUT_CYC)) |=> (bit_cnt_q == '0));
  // R2: the bit counter never passes the last frame bit
  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    bit_cnt_q <= LAST_BIT);
  // R7: a frame ends as a good byte or as an error, never both
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(byte_vld_o && err_o));

endmodule

// File: rtl/ps2_scan_decode.sv
module ps2_scan_decode
  import ps2_key_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       err_i,
  output logic       key_valid_o,
  output logic [7:0] key_code_o,
  output logic       key_ext_o,
  output logic       key_rel_o,
  output logic       frame_err_o
);

  logic ext_pend_q;
  logic rel_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_pend_q  <= 1'b0;
      rel_pend_q  <= 1'b0;
      key_valid_o <= 1'b0;
      key_code_o  <= '0;
      key_ext_o   <= 1'b0;
      key_rel_o   <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      key_valid_o <= 1'b0;
      frame_err_o <= 1'b0;
      if (err_i) begin
        ext_pend_q  <= 1'b0;
        rel_pend_q  <= 1'b0;
        frame_err_o <= 1'b1;
      end else if (byte_vld_i) begin
        unique case (byte_i)
          PFX_EXT: ext_pend_q <= 1'b1;
          PFX_REL: rel_pend_q <= 1'b1;
          default: begin
            key_valid_o <= 1'b1;
            key_code_o  <= byte_i;
            key_ext_o   <= ext_pend_q;
            key_rel_o   <= rel_pend_q;
            ext_pend_q  <= 1'b0;
            rel_pend_q  <= 1'b0;
          end
        endcase
      end
    end
  end

  // R3: prefix bytes never produce an event
  a_r3_prefix_silent: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_i && !err_i && (byte_i == PFX_EXT || byte_i == PFX_REL)) |=> !key_valid_o);
  // R4: the extended prefix is remembered
  a_r4_ext_held: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_i && !err_i && byte_i == PFX_EXT) |=> ext_pend_q);
  // R5: no prefix survives an event
  a_r5_flags_cleared: assert property (@(posedge clk) disable iff (rst)
    key_valid_o |-> (!ext_pend_q && !rel_pend_q));
  // R6: an error flushes the prefixes and reports no key
  a_r6_err_flush: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> (!ext_pend_q && !rel_pend_q && !key_valid_o));

endmodule

// File: rtl/ps2_key_rx.sv
module ps2_key_rx #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4,
  parameter int unsigned TIMEOUT_CYC = 25000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       key_valid_o,
  output logic [7:0] key_code_o,
  output logic       key_ext_o,
  output logic       key_rel_o,
  output logic       frame_err_o
);

  logic [1:0] raw_lines;
  logic [1:0] clean_lines;
  logic       byte_vld;
  logic [7:0] byte_val;
  logic       byte_err;

  assign raw_lines = {ps2_dat_i, ps2_clk_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    ps2_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rst    (rst),
      .line_i (raw_lines[g]),
      .level_o(clean_lines[g])
    );
  end

  ps2_frame_rx #(
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .kclk_i    (clean_lines[0]),
    .kdat_i    (clean_lines[1]),
    .byte_vld_o(byte_vld),
    .byte_o    (byte_val),
    .err_o     (byte_err)
  );

  ps2_scan_decode u_dec (
    .clk        (clk),
    .rst        (rst),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_val),
    .err_i      (byte_err),
    .key_valid_o(key_valid_o),
    .key_code_o (key_code_o),
    .key_ext_o  (key_ext_o),
    .key_rel_o  (key_rel_o),
    .frame_err_o(frame_err_o)
  );

  // R10: event and error strobes are exclusive
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(key_valid_o && frame_err_o));
  // R2: an event strobe lasts a single cycle
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    key_valid_o |=> !key_valid_o);

endmodule

// File: tb/ps2_key_rx_test.sv
module ps2_key_rx_test;

  localparam int HP  = 20;    // half period of the keyboard clock, system cycles
  localparam int TMO = 1000;
  localparam int NV  = 23;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ps2_clk = 1'b1;
  logic       ps2_dat = 1'b1;
  logic       key_valid_o;
  logic [7:0] key_code_o;
  logic       key_ext_o;
  logic       key_rel_o;
  logic       frame_err_o;

  int nchk = 0;
  int nerr = 0;
  int ev_cnt = 0;
  int er_cnt = 0;
  int cyc = 0;
  logic [7:0] last_code = '0;
  logic       last_ext = 1'b0;
  logic       last_rel = 1'b0;

  always #2 clk = ~clk;

  ps2_key_rx #(.SYNC_STAGES(2), .FILT_LEN(4), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst(rst), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
    .key_valid_o(key_valid_o), .key_code_o(key_code_o), .key_ext_o(key_ext_o),
    .key_rel_o(key_rel_o), .frame_err_o(frame_err_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (key_valid_o) begin
        ev_cnt    <= ev_cnt + 1;
        last_code <= key_code_o;
        last_ext  <= key_ext_o;
        last_rel  <= key_rel_o;
      end
      if (frame_err_o) er_cnt <= er_cnt + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    ps2_dat = b;
    wait_cyc(HP);
    ps2_clk = 1'b0;
    wait_cyc(HP);
    ps2_clk = 1'b1;
  endtask

  // kind: 0 good, 1 bad parity, 2 start bit high, 3 stop bit low
  task automatic send_frame(input logic [7:0] b, input logic [1:0] kind, input int nbits);
    logic [10:0] f;
    f[0]   = (kind == 2'd2);
    f[8:1] = b;
    f[9]   = ~(^b) ^ (kind == 2'd1);
    f[10]  = (kind != 2'd3);
    for (int i = 0; i < nbits; i++) send_bit(f[i]);
    ps2_dat = 1'b1;
  endtask

  // {req[3:0], kind[1:0], byte[7:0], evt, code[7:0], ext, rel, err}
  localparam logic [25:0] VEC [NV] = '{
    {4'd2, 2'd0, 8'h16, 1'b1, 8'h16, 1'b0, 1'b0, 1'b0}, // R2 plain make "1"
    {4'd2, 2'd0, 8'h1C, 1'b1, 8'h1C, 1'b0, 1'b0, 1'b0}, // R2 plain make "A"
    {4'd3, 2'd0, 8'hF0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R3 release prefix silent
    {4'd3, 2'd0, 8'h16, 1'b1, 8'h16, 1'b0, 1'b1, 1'b0}, // R3 release of "1"
    {4'd4, 2'd0, 8'hE0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R4 extended prefix silent
    {4'd4, 2'd0, 8'h6B, 1'b1, 8'h6B, 1'b1, 1'b0, 1'b0}, // R4 left arrow make
    {4'd4, 2'd0, 8'hE0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    {4'd4, 2'd0, 8'hF0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    {4'd4, 2'd0, 8'h6B, 1'b1, 8'h6B, 1'b1, 1'b1, 1'b0}, // R4 left arrow break
    {4'd5, 2'd0, 8'h1C, 1'b1, 8'h1C, 1'b0, 1'b0, 1'b0}, // R5 flags gone
    {4'd4, 2'd0, 8'hE0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    {4'd4, 2'd0, 8'hF0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    {4'd4, 2'd0, 8'h14, 1'b1, 8'h14, 1'b1, 1'b1, 1'b0}, // R4 right ctrl break
    {4'd6, 2'd0, 8'hE0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R6
    {4'd6, 2'd1, 8'h6B, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R6 bad parity
    {4'd6, 2'd0, 8'h6B, 1'b1, 8'h6B, 1'b0, 1'b0, 1'b0}, // R6 prefix flushed
    {4'd7, 2'd0, 8'hF0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R7
    {4'd7, 2'd3, 8'h1C, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R7 stop bit low
    {4'd7, 2'd0, 8'h1C, 1'b1, 8'h1C, 1'b0, 1'b0, 1'b0}, // R7 release flushed
    {4'd7, 2'd2, 8'h16, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R7 start bit high
    {4'd4, 2'd0, 8'hF0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R4 reversed prefix order
    {4'd4, 2'd0, 8'hE0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    {4'd4, 2'd0, 8'h14, 1'b1, 8'h14, 1'b1, 1'b1, 1'b0}  // R4
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int e0, r0;
    wait_cyc(5);
    // R1: reset state
    chk("R1 valid in reset", int'(key_valid_o), 0);
    chk("R1 error in reset", int'(frame_err_o), 0);
    rst = 1'b0;
    wait_cyc(20);
    chk("R1 flags after reset", int'({key_ext_o, key_rel_o}), 0);
    chk("R1 no events after reset", ev_cnt + er_cnt, 0);

    for (int v = 0; v < NV; v++) begin
      e0 = ev_cnt;
      r0 = er_cnt;
      send_frame(VEC[v][19:12], VEC[v][21:20], 11);
      wait_cyc(4 * HP);
      chk($sformatf("R%0d vec %0d events", VEC[v][25:22], v), ev_cnt - e0, int'(VEC[v][11]));
      chk($sformatf("R%0d vec %0d errors", VEC[v][25:22], v), er_cnt - r0, int'(VEC[v][0]));
      if (VEC[v][11]) begin
        chk($sformatf("R%0d vec %0d code", VEC[v][25:22], v), int'(last_code), int'(VEC[v][10:3]));
        chk($sformatf("R%0d vec %0d ext", VEC[v][25:22], v), int'(last_ext), int'(VEC[v][2]));
        chk($sformatf("R%0d vec %0d rel", VEC[v][25:22], v), int'(last_rel), int'(VEC[v][1]));
      end
    end

    // R8: stalled partial frame dropped, next frame aligned
    e0 = ev_cnt;
    r0 = er_cnt;
    send_frame(8'h3A, 2'd0, 5);
    wait_cyc(TMO + 200);
    chk("R8 no output from partial frame", (ev_cnt - e0) + (er_cnt - r0), 0);
    send_frame(8'h1C, 2'd0, 11);
    wait_cyc(4 * HP);
    chk("R8 frame after stall events", ev_cnt - e0, 1);
    chk("R8 frame after stall errors", er_cnt - r0, 0);
    chk("R8 frame after stall code", int'(last_code), 8'h1C);

    // R9: short clock pulse ignored
    e0 = ev_cnt;
    r0 = er_cnt;
    ps2_clk = 1'b0;
    wait_cyc(2);
    ps2_clk = 1'b1;
    wait_cyc(4 * HP);
    send_frame(8'h29, 2'd0, 11);
    wait_cyc(4 * HP);
    chk("R9 glitch then frame events", ev_cnt - e0, 1);
    chk("R9 glitch then frame errors", er_cnt - r0, 0);
    chk("R9 glitch then frame code", int'(last_code), 8'h29);

    // R10 is covered by the strobe-count checks above plus the RTL property
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule